// File: doc/BRIEF.md
# Quadrature Step Decoder with Move Strobe

This block watches the two square-wave phase signals of an incremental rotary encoder, which sit a quarter period apart. Both lines are brought into the clock domain through a chain of flip-flops. The decoder then compares each synchronized sample with the one taken a cycle earlier. Whenever exactly one line has toggled, it emits a single-cycle move strobe together with a direction bit. Whenever both lines toggled in the same cycle, which cannot happen on a healthy encoder, it emits a single-cycle error pulse and no strobe.

The direction bit comes from a single XOR of the earlier A sample with the present B sample. Its value is only meaningful in the cycle in which the move strobe is high. In any other cycle it may hold any value, and logic downstream must qualify it with the strobe. A typical consumer is a position counter that counts up or down on each strobe.

Top module: `qdec_top`

## Requirements
- R1: With the default SYNC_STAGES of 2, a single-line change that is set up before clock edge n gives a move strobe in the cycle after edge n+2. Total latency is three edges.
- R2: Each cycle the decoder stores the current synchronized pair as the reference for the next cycle. A line that toggles and then holds therefore produces only one event.
- R3: The move strobe `move_o` is high for exactly one cycle for each single-line change. It stays low while both lines hold their levels.
- R4: When both lines change between two consecutive samples, `err_o` is high for one cycle and `move_o` stays low. The two outputs are never high together.
- R5: While `move_o` is high, `dir_o` equals the previous A sample XOR the current B sample. The sequence (A,B) = 00→10→11→01→00, where A leads, gives `dir_o` = 0 (clockwise). The sequence 00→01→11→10→00, where B leads, gives `dir_o` = 1 (counter-clockwise).
- R6: While `rst` is high, `move_o` and `err_o` are low. During reset the reference sample keeps loading from the synchronized inputs, so levels that settle during reset produce no strobe after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| dir_o | output | 1 | Direction bit, 0 = clockwise, 1 = counter-clockwise; valid only with `move_o` |
| move_o | output | 1 | One-cycle strobe for a single-line step |
| err_o | output | 1 | One-cycle pulse for a simultaneous change of both lines |

## Verification
The bench sweeps all sixteen pairs of previous and next input levels. This sweep separates idle pairs (no output), single-line steps (strobe with a computed direction) and double changes (error only). Full clockwise and counter-clockwise rotations confirm that the direction bit follows the phase order and not just the levels. Long idle stretches show that the strobe is not stuck or repeating. Toggling the inputs during reset shows that no stale strobe appears once reset is released.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef struct packed {
        logic a;
        logic b;
    } quad_t;

    typedef enum logic [1:0] {
        EV_IDLE    = 2'b00,
        EV_STEP    = 2'b01,
        EV_ILLEGAL = 2'b10
    } qevent_e;

    function automatic qevent_e classify_pair(quad_t prev, quad_t cur);
        logic ta;
        logic tb;
        ta = prev.a ^ cur.a;
        tb = prev.b ^ cur.b;
        if (ta && tb)
            return EV_ILLEGAL;
        else if (ta || tb)
            return EV_STEP;
        else
            return EV_IDLE;
    endfunction

    function automatic logic step_direction(quad_t prev, quad_t cur);
        return prev.a ^ cur.b;
    endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) chain[0] <= din;

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) chain[g] <= chain[g-1];
        end
    endgenerate

    assign dout = chain[LAST];
endmodule

// File: rtl/qdec_sample.sv
module qdec_sample
    import qdec_pkg::*;
(
    input  logic  clk,
    input  quad_t cur,
    output quad_t prev
);
    // Loads in reset too: the reference always tracks the synchronized input.
    always_ff @(posedge clk) prev <= cur;
endmodule

// File: rtl/qdec_classify.sv
module qdec_classify
    import qdec_pkg::*;
(
    input  quad_t prev,
    input  quad_t cur,
    output logic  step,
    output logic  illegal,
    output logic  dir
);
    qevent_e ev;

    always_comb begin
        ev      = classify_pair(prev, cur);
        step    = (ev == EV_STEP);
        illegal = (ev == EV_ILLEGAL);
        dir     = step_direction(prev, cur);
    end
endmodule

// File: rtl/qdec_top.sv
module qdec_top
    import qdec_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enc_a,
    input  logic enc_b,
    output logic dir_o,
    output logic move_o,
    output logic err_o
);
    localparam int NCH = $bits(quad_t);

    logic [NCH-1:0] sync_bits;
    quad_t          cur_s;
    quad_t          prev_s;
    logic           step_c;
    logic           illegal_c;
    logic           dir_c;

    qdec_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  ({enc_a, enc_b}),
        .dout (sync_bits)
    );

    assign cur_s = quad_t'(sync_bits);

    qdec_sample u_sample (
        .clk  (clk),
        .cur  (cur_s),
        .prev (prev_s)
    );

    qdec_classify u_class (
        .prev    (prev_s),
        .cur     (cur_s),
        .step    (step_c),
        .illegal (illegal_c),
        .dir     (dir_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            move_o <= 1'b0;
            err_o  <= 1'b0;
            dir_o  <= 1'b0;
        end else begin
            move_o <= step_c;
            err_o  <= illegal_c;
            dir_o  <= dir_c;
        end
    end

    // R4: strobe and error are mutually exclusive
    a_r4_excl: assert property (@(posedge clk) disable iff (rst)
        !(move_o && err_o));

    // R3: a strobe follows a cycle in which exactly one line differed from its reference
    a_r3_single: assert property (@(posedge clk) disable iff (rst)
        move_o |-> $countones($past(cur_s ^ prev_s)) == 1);

    // R4: an error follows a cycle in which both lines differed
    a_r4_double: assert property (@(posedge clk) disable iff (rst)
        err_o |-> ($past(cur_s ^ prev_s) == 2'b11));

    // R2: the reference equals the synchronized pair of the previous cycle
    a_r2_ref: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (prev_s == $past(cur_s)));

    // R6: outputs quiet in the cycle after a reset cycle
    a_r6_quiet: assert property (@(posedge clk)
        rst |=> (!move_o && !err_o));

    // R5: a clockwise step from rest (A rises while B stays low) reports 0
    a_r5_cw: assert property (@(posedge clk) disable iff (rst)
        (move_o && $past(prev_s) == 2'b00 && $past(cur_s) == 2'b10) |-> !dir_o);
endmodule

// File: tb/tb_qdec_top.sv
`timescale 1ns/1ps
module tb_qdec_top;
    logic clk = 1'b0;
    logic rst;
    logic enc_a, enc_b;
    logic dir_o, move_o, err_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic [1:0] last;

    always #2.5 clk = ~clk;

    qdec_top dut (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b),
        .dir_o(dir_o), .move_o(move_o), .err_o(err_o)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic drive(logic [1:0] ab);
        @(negedge clk);
        enc_a = ab[1];
        enc_b = ab[0];
    endtask

    task automatic settle(logic [1:0] ab);
        drive(ab);
        repeat (5) @(posedge clk);
        last = ab;
    endtask

    // Apply a new pair and check the outputs three edges later (R1), then one cycle after that.
    task automatic step(logic [1:0] ab, string req);
        logic [1:0] ch;
        logic       e_move, e_err, e_dir;
        ch     = last ^ ab;
        e_move = (ch == 2'b01) || (ch == 2'b10);
        e_err  = (ch == 2'b11);
        e_dir  = last[1] ^ ab[0];
        drive(ab);
        repeat (3) @(posedge clk);
        #1;
        chk(req, "move", move_o, e_move);
        chk(req, "err", err_o, e_err);
        if (e_move) chk(req, "dir", dir_o, e_dir);
        @(posedge clk);
        #1;
        chk("R3", "move one cycle", move_o, 1'b0);
        chk("R4", "err one cycle", err_o, 1'b0);
        last = ab;
    endtask

    initial begin
        rst = 1'b1; enc_a = 1'b0; enc_b = 1'b0; last = 2'b00;
        repeat (5) @(posedge clk);
        #1;
        chk("R6", "reset move", move_o, 1'b0);
        chk("R6", "reset err", err_o, 1'b0);
        @(negedge clk); rst = 1'b0;
        repeat (4) @(posedge clk);

        // Sweep every previous/next pair (R1, R3, R4, R5)
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 4; c++) begin
                settle(2'(p));
                step(2'(c), "R1_R3_R4_R5 sweep");
            end
        end

        // Clockwise rotations: A leads, dir 0 (R5)
        settle(2'b00);
        for (int k = 0; k < 2; k++) begin
            step(2'b10, "R5 cw"); step(2'b11, "R5 cw");
            step(2'b01, "R5 cw"); step(2'b00, "R5 cw");
        end
        // Counter-clockwise rotations: B leads, dir 1 (R5)
        for (int k = 0; k < 2; k++) begin
            step(2'b01, "R5 ccw"); step(2'b11, "R5 ccw");
            step(2'b10, "R5 ccw"); step(2'b00, "R5 ccw");
        end

        // Idle hold: no strobe (R3, R2)
        settle(2'b11);
        for (int k = 0; k < 20; k++) begin
            @(posedge clk); #1;
            chk("R3", "idle move", move_o, 1'b0);
            chk("R2", "idle err", err_o, 1'b0);
        end

        // Inputs change during reset: nothing afterwards (R6)
        @(negedge clk); rst = 1'b1;
        drive(2'b00);
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); #1;
            chk("R6", "in reset move", move_o, 1'b0);
            chk("R6", "in reset err", err_o, 1'b0);
        end
        @(negedge clk); rst = 1'b0;
        last = 2'b00;
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); #1;
            chk("R6", "post reset move", move_o, 1'b0);
            chk("R6", "post reset err", err_o, 1'b0);
        end
        step(2'b10, "R6 first step after reset");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule